// File: doc/BRIEF.md
# Adaptive Traffic Phase-Switch Controller

This block decides when a two-arm intersection should leave its current light phase. It tracks how many cars wait on each arm. An entry sensor pulse raises an arm's count and an exit sensor pulse lowers it. It also measures how long the current phase has lasted, in units of an external time tick. From these values and a set of programmable weights and time limits, it raises a switch request for a separate light-sequencing state machine.

The rule depends on the phase type. A straight phase weighs the queue lengths of both arms through a per-arm demand value, `alpha * n_own + beta - n_other`. The value is bounded below by a minimum phase time and above by a maximum phase time. A left-turn phase has its own limits and also ends when the favoured arm's queue has stood still for five ticks. A pedestrian phase ends on a single time limit.

The sequencer answers each request by pulsing `tmr_clr`. That pulse zeroes the phase timer and re-arms the block. All pins are plain control and status signals, and there is no streaming data path.

Top module: `tpsw_ctrl`

## Requirements
- R1: Each arm's count (`cnt1`, `cnt2`) rises by one on a cycle with only its entry pulse high and falls by one on a cycle with only its exit pulse high. Both pulses high on the same arm in the same cycle leave that count unchanged. Bit 0 of `ent_pulse`/`ext_pulse` is arm 1 and bit 1 is arm 2.
- R2: A count stays at 0 on an exit pulse and stays at CNT_MAX (default 50) on an entry pulse.
- R3: `elapsed` rises by one per cycle with `tick` high and saturates at 2^TW-1 (255). A cycle with `tmr_clr` high sets it to 0 at the next edge, even when `tick` is also high.
- R4: In a straight phase (`phase_kind` = 0), no request is raised while `elapsed` is below the favoured arm's minimum (`tmin1` when `fav_arm` = 0, `tmin2` when `fav_arm` = 1). This minimum takes priority over every other condition.
- R5: In a straight phase, once `elapsed` is at or above the favoured arm's minimum and also at or above its maximum (`tmax1`/`tmax2`), a request is raised whatever the queues hold.
- R6: In a straight phase with `elapsed` at or above the minimum, a request is raised when the favoured arm's count is zero or its demand is zero or negative. Arm 1's demand is `alpha1*n1 + beta1 - n2` and arm 2's is `alpha2*n2 + beta2 - n1`, evaluated in signed arithmetic without overflow.
- R7: In a left-turn phase (`phase_kind` = 1), no request is raised while `elapsed` < `lmin`. At or above `lmin`, a request is raised when `elapsed` >= `lmax` or when the favoured arm's count has not changed for 5 ticks. That 5-tick window is counted from the last `tmr_clr` or the last change of that count.
- R8: In a pedestrian phase (`phase_kind` = 2), a request is raised once `elapsed` >= `plim`.
- R9: With `phase_kind` = 3 (hold), no request is ever raised.
- R10: `sw_req` rises in the cycle after the decision condition first holds and stays high for exactly one cycle. No further request is raised until a `tmr_clr` pulse. A decision condition that coincides with `tmr_clr` raises no request.
- R11: After reset, `cnt1`, `cnt2` and `elapsed` are 0, `sw_req` is 0 and the block is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ent_pulse | input | 2 | Entry sensor pulses, bit 0 arm 1, bit 1 arm 2 |
| ext_pulse | input | 2 | Exit sensor pulses, bit 0 arm 1, bit 1 arm 2 |
| tick | input | 1 | Time unit strobe for the phase timer |
| tmr_clr | input | 1 | Phase change acknowledge from the sequencer; clears the timer and re-arms |
| phase_kind | input | 2 | 0 straight, 1 left turn, 2 pedestrian, 3 hold |
| fav_arm | input | 1 | Favoured arm: 0 arm 1, 1 arm 2 |
| alpha1 | input | AW | Queue weight of arm 1 |
| beta1 | input | BW | Offset of arm 1 |
| alpha2 | input | AW | Queue weight of arm 2 |
| beta2 | input | BW | Offset of arm 2 |
| tmin1 | input | TW | Straight minimum time of arm 1 |
| tmax1 | input | TW | Straight maximum time of arm 1 |
| tmin2 | input | TW | Straight minimum time of arm 2 |
| tmax2 | input | TW | Straight maximum time of arm 2 |
| lmin | input | TW | Left-turn minimum time |
| lmax | input | TW | Left-turn maximum time |
| plim | input | TW | Pedestrian phase time |
| sw_req | output | 1 | One-cycle switch request |
| cnt1 | output | CW | Queue count of arm 1 |
| cnt2 | output | CW | Queue count of arm 2 |
| elapsed | output | TW | Time spent in the current phase |

## Verification
Two pairs of functions can act in the same cycle. Counting can see an entry and an exit on one arm together. Re-arming can meet a decision when `tmr_clr` arrives while the switch condition already holds. The first pair is provoked by driving both sensor bits of one arm in one cycle. It is judged by reading the count unchanged one cycle later. The second pair is provoked by holding `tmr_clr` high for several cycles over a phase whose condition is true from time zero. It is judged by seeing `sw_req` stay low throughout and then pulse exactly once after the release. The left-turn stall window is reset by a count change in mid-phase, and the request must appear five ticks after that change rather than after the clear.

// File: rtl/tpsw_pkg.sv
package tpsw_pkg;

  typedef enum logic [1:0] {
    PH_STRAIGHT = 2'd0,
    PH_LEFT     = 2'd1,
    PH_PED      = 2'd2,
    PH_HOLD     = 2'd3
  } phase_e;

  localparam int NUM_ARMS = 2;

  function automatic int wider(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/tpsw_queue.sv
module tpsw_queue #(
  parameter int CNT_MAX = 50,
  localparam int CW = $clog2(CNT_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ent,
  input  logic          ext,
  output logic [CW-1:0] cnt,
  output logic          chg
);

  localparam logic [CW-1:0] CAP = CW'(CNT_MAX);

  logic up, dn;

  always_comb begin
    up  = ent && !ext && (cnt != CAP);
    dn  = ext && !ent && (cnt != '0);
    chg = up || dn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (up) begin
      cnt <= cnt + 1'b1;
    end else if (dn) begin
      cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/tpsw_timer.sv
module tpsw_timer #(
  parameter int TW          = 8,
  parameter int STALL_TICKS = 5,
  localparam int SCW = $clog2(STALL_TICKS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          clr,
  input  logic          fav_chg,
  output logic [TW-1:0] elapsed,
  output logic          stall_done
);

  localparam logic [TW-1:0]  TSAT = '1;
  localparam logic [SCW-1:0] SSAT = SCW'(STALL_TICKS);

  logic [SCW-1:0] stall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed <= '0;
    end else if (clr) begin
      elapsed <= '0;
    end else if (tick && (elapsed != TSAT)) begin
      elapsed <= elapsed + 1'b1;
    end
  end

  // ticks since the favoured queue last moved
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall <= '0;
    end else if (clr || fav_chg) begin
      stall <= '0;
    end else if (tick && (stall != SSAT)) begin
      stall <= stall + 1'b1;
    end
  end

  assign stall_done = (stall == SSAT);

endmodule

// File: rtl/tpsw_demand.sv
module tpsw_demand #(
  parameter int CW = 6,
  parameter int AW = 4,
  parameter int BW = 4,
  localparam int FW = tpsw_pkg::wider(AW + CW, BW) + 2
) (
  input  logic [CW-1:0] n_own,
  input  logic [CW-1:0] n_other,
  input  logic [AW-1:0] alpha,
  input  logic [BW-1:0] beta,
  output logic          nonpos
);

  logic [AW+CW-1:0]     prod;
  logic signed [FW-1:0] f;

  always_comb begin
    prod   = AW'(alpha) * (AW+CW)'(n_own);
    f      = $signed(FW'(prod)) + $signed(FW'(beta)) - $signed(FW'(n_other));
    nonpos = f[FW-1] || (f == '0);
  end

endmodule

// File: rtl/tpsw_decide.sv
module tpsw_decide
  import tpsw_pkg::*;
#(
  parameter int TW = 8
) (
  input  phase_e        phase,
  input  logic [TW-1:0] elapsed,
  input  logic [TW-1:0] smin,
  input  logic [TW-1:0] smax,
  input  logic [TW-1:0] lmin,
  input  logic [TW-1:0] lmax,
  input  logic [TW-1:0] plim,
  input  logic          fav_empty,
  input  logic          fav_nonpos,
  input  logic          stall_done,
  output logic          want
);

  always_comb begin
    want = 1'b0;
    unique case (phase)
      PH_STRAIGHT: want = (elapsed >= smin) &&
                          ((elapsed >= smax) || fav_empty || fav_nonpos);
      PH_LEFT:     want = (elapsed >= lmin) &&
                          ((elapsed >= lmax) || stall_done);
      PH_PED:      want = (elapsed >= plim);
      default:     want = 1'b0;
    endcase
  end

endmodule

// File: rtl/tpsw_ctrl.sv
module tpsw_ctrl
  import tpsw_pkg::*;
#(
  parameter int CNT_MAX     = 50,
  parameter int AW          = 4,
  parameter int BW          = 4,
  parameter int TW          = 8,
  parameter int STALL_TICKS = 5,
  localparam int CW = $clog2(CNT_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    ent_pulse,
  input  logic [1:0]    ext_pulse,
  input  logic          tick,
  input  logic          tmr_clr,
  input  logic [1:0]    phase_kind,
  input  logic          fav_arm,
  input  logic [AW-1:0] alpha1,
  input  logic [BW-1:0] beta1,
  input  logic [AW-1:0] alpha2,
  input  logic [BW-1:0] beta2,
  input  logic [TW-1:0] tmin1,
  input  logic [TW-1:0] tmax1,
  input  logic [TW-1:0] tmin2,
  input  logic [TW-1:0] tmax2,
  input  logic [TW-1:0] lmin,
  input  logic [TW-1:0] lmax,
  input  logic [TW-1:0] plim,
  output logic          sw_req,
  output logic [CW-1:0] cnt1,
  output logic [CW-1:0] cnt2,
  output logic [TW-1:0] elapsed
);

  logic [CW-1:0] cnt     [NUM_ARMS];
  logic [AW-1:0] alpha_v [NUM_ARMS];
  logic [BW-1:0] beta_v  [NUM_ARMS];
  logic [NUM_ARMS-1:0] chg;
  logic [NUM_ARMS-1:0] nonpos;

  assign alpha_v[0] = alpha1;
  assign alpha_v[1] = alpha2;
  assign beta_v[0]  = beta1;
  assign beta_v[1]  = beta2;

  for (genvar g = 0; g < NUM_ARMS; g++) begin : g_arm
    tpsw_queue #(.CNT_MAX(CNT_MAX)) u_q (
      .clk (clk),
      .rst_n(rst_n),
      .ent (ent_pulse[g]),
      .ext (ext_pulse[g]),
      .cnt (cnt[g]),
      .chg (chg[g])
    );
    tpsw_demand #(.CW(CW), .AW(AW), .BW(BW)) u_d (
      .n_own  (cnt[g]),
      .n_other(cnt[NUM_ARMS-1-g]),
      .alpha  (alpha_v[g]),
      .beta   (beta_v[g]),
      .nonpos (nonpos[g])
    );
  end

  assign cnt1 = cnt[0];
  assign cnt2 = cnt[1];

  logic          fav_chg, fav_empty, fav_nonpos, stall_done;
  logic [TW-1:0] smin, smax;

  always_comb begin
    fav_chg    = fav_arm ? chg[1]    : chg[0];
    fav_empty  = fav_arm ? (cnt[1] == '0) : (cnt[0] == '0);
    fav_nonpos = fav_arm ? nonpos[1] : nonpos[0];
    smin       = fav_arm ? tmin2     : tmin1;
    smax       = fav_arm ? tmax2     : tmax1;
  end

  tpsw_timer #(.TW(TW), .STALL_TICKS(STALL_TICKS)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .clr       (tmr_clr),
    .fav_chg   (fav_chg),
    .elapsed   (elapsed),
    .stall_done(stall_done)
  );

  logic want;

  tpsw_decide #(.TW(TW)) u_dec (
    .phase     (phase_e'(phase_kind)),
    .elapsed   (elapsed),
    .smin      (smin),
    .smax      (smax),
    .lmin      (lmin),
    .lmax      (lmax),
    .plim      (plim),
    .fav_empty (fav_empty),
    .fav_nonpos(fav_nonpos),
    .stall_done(stall_done),
    .want      (want)
  );

  logic armed, fire;

  assign fire = want && armed && !tmr_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b1;
      sw_req <= 1'b0;
    end else begin
      sw_req <= fire;
      if (tmr_clr) begin
        armed <= 1'b1;
      end else if (fire) begin
        armed <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/tpsw_ctrl_chk.sv
module tpsw_ctrl_chk #(
  parameter int CNT_MAX = 50,
  parameter int TW      = 8,
  localparam int CW = $clog2(CNT_MAX + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    ent_pulse,
  input logic [1:0]    ext_pulse,
  input logic          tick,
  input logic          tmr_clr,
  input logic [1:0]    phase_kind,
  input logic          fav_arm,
  input logic [TW-1:0] tmin1,
  input logic [TW-1:0] tmin2,
  input logic [TW-1:0] lmin,
  input logic [TW-1:0] plim,
  input logic          sw_req,
  input logic [CW-1:0] cnt1,
  input logic [CW-1:0] cnt2,
  input logic [TW-1:0] elapsed
);

  localparam logic [CW-1:0] CAP  = CW'(CNT_MAX);
  localparam logic [TW-1:0] TSAT = '1;

  logic [TW-1:0] fav_min;
  assign fav_min = fav_arm ? tmin2 : tmin1;

  assert_pair_a1_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_pulse[0] && ext_pulse[0]) |=> $stable(cnt1));
  assert_pair_a2_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_pulse[1] && ext_pulse[1]) |=> $stable(cnt2));
  assert_inc_a1_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_pulse[0] && !ext_pulse[0] && cnt1 != CAP) |=> cnt1 == $past(cnt1) + 1'b1);
  assert_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt1 <= CAP) && (cnt2 <= CAP));
  assert_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_clr |=> elapsed == '0);
  assert_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_clr && tick && elapsed != TSAT) |=> elapsed == $past(elapsed) + 1'b1);
  assert_min_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_req && $past(phase_kind) == 2'd0) |-> $past(elapsed) >= $past(fav_min));
  assert_left_min_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_req && $past(phase_kind) == 2'd1) |-> $past(elapsed) >= $past(lmin));
  assert_ped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_req && $past(phase_kind) == 2'd2) |-> $past(elapsed) >= $past(plim));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sw_req |-> $past(phase_kind) != 2'd3);
  assert_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sw_req |=> !sw_req);
  assert_clr_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_clr |=> !sw_req);

endmodule

bind tpsw_ctrl tpsw_ctrl_chk #(.CNT_MAX(CNT_MAX), .TW(TW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ent_pulse (ent_pulse),
  .ext_pulse (ext_pulse),
  .tick      (tick),
  .tmr_clr   (tmr_clr),
  .phase_kind(phase_kind),
  .fav_arm   (fav_arm),
  .tmin1     (tmin1),
  .tmin2     (tmin2),
  .lmin      (lmin),
  .plim      (plim),
  .sw_req    (sw_req),
  .cnt1      (cnt1),
  .cnt2      (cnt2),
  .elapsed   (elapsed)
);

// File: tb/sim_tpsw_ctrl.sv
`timescale 1ns/1ps
module sim_tpsw_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ent_pulse = '0, ext_pulse = '0;
  logic       tick = 1'b0, tmr_clr = 1'b0;
  logic [1:0] phase_kind = 2'd3;
  logic       fav_arm = 1'b0;
  logic [3:0] alpha1 = '0, beta1 = '0, alpha2 = '0, beta2 = '0;
  logic [7:0] tmin1 = '0, tmax1 = '0, tmin2 = '0, tmax2 = '0;
  logic [7:0] lmin = '0, lmax = '0, plim = '0;
  logic       sw_req;
  logic [5:0] cnt1, cnt2;
  logic [7:0] elapsed;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tpsw_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ent_pulse(ent_pulse), .ext_pulse(ext_pulse),
    .tick(tick), .tmr_clr(tmr_clr), .phase_kind(phase_kind), .fav_arm(fav_arm),
    .alpha1(alpha1), .beta1(beta1), .alpha2(alpha2), .beta2(beta2),
    .tmin1(tmin1), .tmax1(tmax1), .tmin2(tmin2), .tmax2(tmax2),
    .lmin(lmin), .lmax(lmax), .plim(plim),
    .sw_req(sw_req), .cnt1(cnt1), .cnt2(cnt2), .elapsed(elapsed)
  );

  // fields: phase, fav, alpha, beta, n1, n2, min, max, expected elapsed (255 = none)
  localparam int NV = 15;
  localparam logic [71:0] VECS [NV] = '{
    {8'd0, 8'd0, 8'd1, 8'd0, 8'd3,  8'd5,  8'd2, 8'd20, 8'd2},
    {8'd0, 8'd0, 8'd2, 8'd1, 8'd3,  8'd5,  8'd2, 8'd20, 8'd20},
    {8'd0, 8'd1, 8'd1, 8'd0, 8'd4,  8'd4,  8'd3, 8'd12, 8'd3},
    {8'd0, 8'd1, 8'd3, 8'd2, 8'd4,  8'd2,  8'd1, 8'd9,  8'd9},
    {8'd0, 8'd0, 8'd5, 8'd5, 8'd0,  8'd7,  8'd4, 8'd15, 8'd4},
    {8'd0, 8'd1, 8'd0, 8'd0, 8'd9,  8'd3,  8'd6, 8'd10, 8'd6},
    {8'd0, 8'd0, 8'd1, 8'd1, 8'd10, 8'd11, 8'd0, 8'd7,  8'd0},
    {8'd1, 8'd0, 8'd1, 8'd9, 8'd5,  8'd0,  8'd2, 8'd30, 8'd5},
    {8'd1, 8'd1, 8'd1, 8'd9, 8'd5,  8'd5,  8'd8, 8'd30, 8'd8},
    {8'd1, 8'd0, 8'd1, 8'd9, 8'd5,  8'd5,  8'd1, 8'd3,  8'd3},
    {8'd2, 8'd0, 8'd9, 8'd9, 8'd4,  8'd4,  8'd0, 8'd14, 8'd14},
    {8'd2, 8'd1, 8'd0, 8'd0, 8'd0,  8'd0,  8'd0, 8'd6,  8'd6},
    {8'd3, 8'd0, 8'd0, 8'd0, 8'd2,  8'd2,  8'd0, 8'd0,  8'd255},
    {8'd0, 8'd0, 8'd7, 8'd7, 8'd20, 8'd1,  8'd5, 8'd11, 8'd11},
    {8'd0, 8'd0, 8'd2, 8'd2, 8'd5,  8'd1,  8'd9, 8'd4,  8'd9}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load(input int n1, input int n2);
    ext_pulse = 2'b11;
    repeat (52) step();
    ext_pulse = 2'b00;
    for (int i = 0; i < 52; i++) begin
      if (i >= n1 && i >= n2) break;
      ent_pulse = {(i < n2), (i < n1)};
      step();
    end
    ent_pulse = 2'b00;
  endtask

  task automatic clear_phase(input logic [1:0] ph);
    phase_kind = ph;
    tmr_clr = 1'b1;
    step();
    tmr_clr = 1'b0;
  endtask

  // walk the phase with a tick every 4th cycle; returns elapsed at first request
  task automatic wait_req(input int limit, output bit seen, output int got);
    seen = 0;
    got = -1;
    for (int k = 0; k < limit; k++) begin
      tick = (k % 4 == 3);
      step();
      tick = 1'b0;
      if (sw_req) begin
        seen = 1;
        got = elapsed;
        break;
      end
    end
  endtask

  task automatic run_vec(input int idx);
    logic [71:0] v;
    int ph, fv, a, b, n1, n2, mn, mx, ex;
    bit seen;
    int got;
    v  = VECS[idx];
    ph = v[71:64]; fv = v[63:56]; a  = v[55:48]; b  = v[47:40];
    n1 = v[39:32]; n2 = v[31:24]; mn = v[23:16]; mx = v[15:8]; ex = v[7:0];
    phase_kind = 2'd3;
    load(n1, n2);
    check($sformatf("R1 vec%0d cnt1", idx), cnt1, n1);
    check($sformatf("R1 vec%0d cnt2", idx), cnt2, n2);
    fav_arm = fv[0];
    alpha1 = fv ? 4'd0 : a[3:0];  beta1 = fv ? 4'd0 : b[3:0];
    alpha2 = fv ? a[3:0] : 4'd0;  beta2 = fv ? b[3:0] : 4'd0;
    tmin1 = fv ? 8'd0 : mn[7:0];  tmax1 = fv ? 8'd1 : mx[7:0];
    tmin2 = fv ? mn[7:0] : 8'd0;  tmax2 = fv ? mx[7:0] : 8'd1;
    lmin = mn[7:0]; lmax = mx[7:0]; plim = mx[7:0];
    clear_phase(ph[1:0]);
    if (ex == 255) begin
      wait_req(200, seen, got);
      check($sformatf("R9 vec%0d request seen", idx), seen, 0);
    end else begin
      wait_req(1500, seen, got);
      check($sformatf("R4 R5 R6 R7 R8 vec%0d request seen", idx), seen, 1);
      check($sformatf("R4 R5 R6 R7 R8 vec%0d elapsed at request", idx), got, ex);
    end
    phase_kind = 2'd3;
  endtask

  initial begin
    bit seen;
    int got;
    int extra;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R11 reset state
    check("R11 cnt1", cnt1, 0);
    check("R11 cnt2", cnt2, 0);
    check("R11 elapsed", elapsed, 0);
    check("R11 sw_req", sw_req, 0);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R1 counting and same-cycle entry/exit
    load(3, 0);
    ent_pulse = 2'b01; ext_pulse = 2'b01; step();
    ent_pulse = 2'b00; ext_pulse = 2'b00;
    check("R1 both pulses arm1", cnt1, 3);
    ext_pulse = 2'b01; step(); ext_pulse = 2'b00;
    check("R1 exit arm1", cnt1, 2);
    ent_pulse = 2'b10; step(); ent_pulse = 2'b00;
    check("R1 entry arm2 leaves arm1", cnt1, 2);
    check("R1 entry arm2", cnt2, 1);

    // R2 saturation
    ent_pulse = 2'b10;
    repeat (60) step();
    ent_pulse = 2'b00;
    check("R2 top saturation", cnt2, 50);
    ext_pulse = 2'b11;
    repeat (55) step();
    ext_pulse = 2'b00;
    check("R2 zero saturation", cnt2, 0);
    check("R2 zero saturation arm1", cnt1, 0);

    // R3 timer
    clear_phase(2'd3);
    tick = 1'b1;
    repeat (5) step();
    check("R3 five ticks", elapsed, 5);
    tmr_clr = 1'b1; step(); tmr_clr = 1'b0; tick = 1'b0;
    check("R3 clear beats tick", elapsed, 0);
    tick = 1'b1;
    repeat (300) step();
    tick = 1'b0;
    check("R3 timer saturation", elapsed, 255);

    // R10 single pulse and re-arm
    fav_arm = 1'b0; tmin1 = 8'd0; tmax1 = 8'd9;
    clear_phase(2'd0);
    check("R10 no request on clear cycle", sw_req, 0);
    step();
    check("R10 request after clear", sw_req, 1);
    check("R6 empty queue at elapsed", elapsed, 0);
    step();
    check("R10 pulse is one cycle", sw_req, 0);
    extra = 0;
    for (int k = 0; k < 40; k++) begin
      tick = (k % 4 == 3); step(); tick = 1'b0;
      if (sw_req) extra++;
    end
    check("R10 no request until clear", extra, 0);

    // R10 clear held while condition is true
    tmr_clr = 1'b1;
    extra = 0;
    for (int k = 0; k < 3; k++) begin
      step();
      if (sw_req) extra++;
    end
    tmr_clr = 1'b0;
    check("R10 clear suppresses request", extra, 0);
    step();
    check("R10 request after clear release", sw_req, 1);
    step();

    // R7 stall window restarts on a count change
    phase_kind = 2'd3;
    load(2, 0);
    fav_arm = 1'b0; lmin = 8'd0; lmax = 8'd50;
    clear_phase(2'd1);
    seen = 0; got = -1;
    for (int k = 0; k < 200; k++) begin
      tick = (k % 4 == 3);
      ent_pulse = (k == 13) ? 2'b01 : 2'b00;
      step();
      tick = 1'b0; ent_pulse = 2'b00;
      if (sw_req) begin seen = 1; got = elapsed; break; end
    end
    check("R7 stall restart request seen", seen, 1);
    check("R7 stall restart elapsed", got, 8);
    check("R1 mid-phase entry", cnt1, 3);
    phase_kind = 2'd3;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule